// File: doc/BRIEF.md
# Connection-Bit Serial Output Sequencer

This block walks a per-location control-bit array of a time-slot switch's connection memory and sends every bit out on one serial pin once per frame. The array holds one bit for each pair of output stream and channel, 16 streams by 32 channels by default. The pin toggles at twice the per-stream bit rate, so a 32-channel frame carries exactly 512 bits. The output stays locked to the frame timing of the serial streams.

The bits are not sent in plain memory order. Each channel slot lasts 16 clocks. During those clocks the block sends, one clock per stream and in rising stream order, the bits that belong to the *next* channel. A downstream device therefore learns a channel's setting one slot before that channel's data appears on the streams.

The block drives a registered read address into the external bit array and takes back a combinational read bit. A frame pulse restarts the frame position at any time. Between pulses the position counter runs freely and wraps every 512 clocks.

Top module: `cco_bit_sequencer`

## Requirements
- R1: While `rst_n` is low, at each rising edge `rd_addr` becomes 1 (stream 0, channel 1) and `ser_out` becomes 0.
- R2: Across 512 consecutive clocks with no frame pulse, `rd_addr` presents every one of the 512 locations exactly once.
- R3: Frame position k (0 to 511) lies in slot s = k / 16 at clock j = k mod 16. At position k the read address is j*32 + ((s+1) mod 32): the stream number sits in address bits 8:5 and the channel number in bits 4:0.
- R4: The bit for location 0 goes out on the first clock of slot 31 (position 496). The bit for location 32 goes out on the second clock of that slot (position 497).
- R5: At each rising edge outside reset, `ser_out` takes the value `rd_bit` holds at that edge. The bit for the address presented during one cycle therefore appears on the pin during the next cycle.
- R6: When `frame_pulse` is high at a rising edge, the position restarts at 0 at that edge: `rd_addr` becomes 1, and one clock later `ser_out` carries the bit for position 0. This holds at any point in the frame.
- R7: Without a frame pulse, the position after 511 is 0, so the sequence repeats with a period of 512 clocks.
- R8: A frame pulse at the edge where the free-running position would wrap from 511 to 0 leaves the address and output sequences unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, twice the per-stream rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | Frame-start strobe, one clock wide, sampled on the rising edge |
| rd_addr | output | 9 | Registered read address into the control-bit array, {stream, channel} |
| rd_bit | input | 1 | Combinational read data from the array at `rd_addr` |
| ser_out | output | 1 | Serial control-bit output |

## Verification
The case hardest to reach from the ports is a frame pulse that arrives in the middle of a frame, while the free-running counter is far from its wrap point. A pulse that lands exactly on the natural wrap is just as hard to reach, because only there do a forced restart and the normal rollover coincide. The bench keeps its own position model and runs for hundreds of clocks without a pulse before it strobes the pulse. It strobes once at position 200 and once on the clock where the model stands at 511. Two array images are used, a scrambled pattern and a pattern with only locations 0 and 32 set, so that misordering and off-by-one-slot errors both show on the pin.

// File: rtl/cco_seq_pkg.sv
// Shared defaults and helpers for the connection-bit sequencer.
// Assumes stream and channel counts are powers of two.
package cco_seq_pkg;
    localparam int unsigned DEF_STREAMS  = 16;
    localparam int unsigned DEF_CHANNELS = 32;
    localparam int unsigned DEF_LEAD     = 1;

    // Channel whose bits are sent during a given slot, `lead` slots ahead.
    function automatic int unsigned lead_channel(int unsigned slot,
                                                 int unsigned lead,
                                                 int unsigned chans);
        return (slot + lead) % chans;
    endfunction
endpackage

// File: rtl/cco_pos_counter.sv
// Frame position counter. It counts clocks within a frame and wraps naturally
// at 2**POS_W. A frame pulse forces the next position to 0.
// Assumes the frame length is a power of two.
module cco_pos_counter #(
    parameter int unsigned POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    output logic [POS_W-1:0] pos_next
);
    logic [POS_W-1:0] pos_q;

    // Next position: a restart on a pulse, otherwise one step on.
    always_comb begin
        pos_next = frame_pulse ? '0 : pos_q + POS_W'(1);
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_next;
    end
endmodule

// File: rtl/cco_loc_map.sv
// Maps a frame position to the array location whose bit is sent there.
// Low SW bits of the position give the stream. The upper CW bits give the
// slot, and the slot advanced by LEAD gives the channel.
module cco_loc_map
    import cco_seq_pkg::*;
#(
    parameter int unsigned SW       = 4,
    parameter int unsigned CW       = 5,
    parameter int unsigned CHANNELS = 32,
    parameter int unsigned LEAD     = 1
) (
    input  logic [SW+CW-1:0] pos,
    output logic [SW+CW-1:0] loc
);
    logic [CW-1:0] slot;
    logic [SW-1:0] stream;
    logic [CW-1:0] chan;

    // Split the position into slot and stream fields.
    always_comb begin
        slot   = pos[SW+CW-1:SW];
        stream = pos[SW-1:0];
    end

    generate
        if ((LEAD % CHANNELS) == 0) begin : g_no_lead
            // No lead: the channel is the slot itself.
            always_comb chan = slot;
        end else begin : g_lead
            // Lead: the channel runs LEAD slots ahead, modulo the channel count.
            always_comb chan = CW'(lead_channel(32'(slot), LEAD, CHANNELS));
        end
    endgenerate

    // Location index is {stream, channel}.
    always_comb loc = {stream, chan};
endmodule

// File: rtl/cco_out_stage.sv
// Output registers. The read address is held in a register so that it
// changes on one edge only. The serial bit is registered from the array's
// combinational read data, so it lags the address by one clock.
module cco_out_stage #(
    parameter int unsigned AW      = 9,
    parameter int unsigned RST_LOC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] loc_next,
    input  logic          rd_bit,
    output logic [AW-1:0] rd_addr,
    output logic          ser_out
);
    // Address register, loaded with the location for the next position.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_addr <= AW'(RST_LOC);
        else        rd_addr <= loc_next;
    end

    // Serial output register, capturing the bit read at the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) ser_out <= 1'b0;
        else        ser_out <= rd_bit;
    end
endmodule

// File: rtl/cco_bit_sequencer.sv
// Connection-bit serial output sequencer (top). It sends one control bit per
// connection-memory location each frame. Each channel's bits for all streams
// go out during the slot before that channel. Assumes STREAMS and CHANNELS are
// powers of two and that the array answers combinationally.
module cco_bit_sequencer
    import cco_seq_pkg::*;
#(
    parameter  int unsigned STREAMS  = DEF_STREAMS,
    parameter  int unsigned CHANNELS = DEF_CHANNELS,
    parameter  int unsigned LEAD     = DEF_LEAD,
    localparam int unsigned SW       = $clog2(STREAMS),
    localparam int unsigned CW       = $clog2(CHANNELS),
    localparam int unsigned AW       = SW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_bit,
    output logic          ser_out
);
    localparam int unsigned RST_LOC = LEAD % CHANNELS;

    logic [AW-1:0] pos_next;
    logic [AW-1:0] loc_next;

    cco_pos_counter #(.POS_W(AW)) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .pos_next    (pos_next)
    );

    cco_loc_map #(.SW(SW), .CW(CW), .CHANNELS(CHANNELS), .LEAD(LEAD)) u_map (
        .pos (pos_next),
        .loc (loc_next)
    );

    cco_out_stage #(.AW(AW), .RST_LOC(RST_LOC)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .loc_next (loc_next),
        .rd_bit   (rd_bit),
        .rd_addr  (rd_addr),
        .ser_out  (ser_out)
    );
endmodule

// File: rtl/cco_bit_sequencer_chk.sv
// Port-level checker for the sequencer, attached by bind.
module cco_bit_sequencer_chk #(
    parameter int unsigned SW       = 4,
    parameter int unsigned CW       = 5,
    parameter int unsigned LEAD_LOC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_pulse,
    input logic [SW+CW-1:0] rd_addr,
    input logic             rd_bit,
    input logic             ser_out
);
    localparam int unsigned AW   = SW + CW;
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0] strm;
    logic [CW-1:0] chn;
    assign strm = rd_addr[AW-1:CW];
    assign chn  = rd_addr[CW-1:0];

    AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> rd_addr == AW'(LEAD_LOC)); // R6

    AST_DATA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ser_out == $past(rd_bit)); // R5

    AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && strm != SMAX) |=>
            (strm == $past(strm) + SW'(1) && chn == $past(chn))); // R3

    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && strm == SMAX) |=>
            (strm == '0 && chn == $past(chn) + CW'(1))); // R7
endmodule

bind cco_bit_sequencer cco_bit_sequencer_chk #(
    .SW(SW), .CW(CW), .LEAD_LOC(RST_LOC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .rd_addr     (rd_addr),
    .rd_bit      (rd_bit),
    .ser_out     (ser_out)
);

// File: tb/sim_cco_bit_sequencer.sv
// Self-checking bench: sweeps whole frames against an arithmetic position model.
module sim_cco_bit_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic [8:0] rd_addr;
    logic       rd_bit;
    logic       ser_out;

    logic mem [0:511];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   k = 0;         // model position of the current rd_addr
    int   last_pos = 0;  // position whose bit is on ser_out
    bit   done = 0;
    bit   seen [0:511];

    always #2 clk = ~clk;  // 250 MHz nominal

    assign rd_bit = mem[rd_addr];

    cco_bit_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .rd_addr(rd_addr), .rd_bit(rd_bit), .ser_out(ser_out)
    );

    function automatic int exp_loc(int p);
        return (p % 16) * 32 + ((p / 16) + 1) % 32;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic pulse);
        int prev;
        prev = k;
        frame_pulse = pulse;
        @(posedge clk);
        @(negedge clk);
        frame_pulse = 1'b0;
        k = pulse ? 0 : (k + 1) % 512;
        last_pos = prev;
        check("R3 address", int'(rd_addr), exp_loc(k));
        check("R5 serial data", int'(ser_out), int'(mem[exp_loc(prev)]));
        if (pulse)
            check("R6 restart address", int'(rd_addr), 1);
        if (!pulse && prev == 511)
            check("R7 wrap to position 0", int'(rd_addr), exp_loc(0));
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = (((a * 7) + (a >> 2)) % 3) == 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 reset address", int'(rd_addr), 1);
        check("R1 reset serial", int'(ser_out), 0);
        rst_n = 1'b1;
        k = 0;
        // Free run from reset across a wrap (R7)
        for (int i = 0; i < 600; i++) step(1'b0);
        // R2 coverage over a full frame after a pulse
        for (int a = 0; a < 512; a++) seen[a] = 0;
        step(1'b1);
        seen[rd_addr] = 1;
        for (int i = 0; i < 511; i++) begin
            step(1'b0);
            seen[rd_addr] = 1;
        end
        begin
            int cnt;
            cnt = 0;
            for (int a = 0; a < 512; a++) cnt += int'(seen[a]);
            check("R2 distinct locations per frame", cnt, 512);
        end
        // R4 with only locations 0 and 32 set
        for (int a = 0; a < 512; a++) mem[a] = (a == 0) || (a == 32);
        step(1'b1);
        for (int i = 0; i < 520; i++) begin
            step(1'b0);
            if (last_pos == 496) check("R4 location 0 at slot 31 clock 0", int'(ser_out), 1);
            if (last_pos == 497) check("R4 location 32 at slot 31 clock 1", int'(ser_out), 1);
            if (last_pos == 495) check("R4 quiet before slot 31", int'(ser_out), 0);
        end
        // R6 mid-frame restart
        for (int a = 0; a < 512; a++) mem[a] = (((a * 13) + (a >> 3)) % 5) < 2;
        while (k != 200) step(1'b0);
        step(1'b1);
        check("R6 restart mid-frame", k, 0);
        for (int i = 0; i < 300; i++) step(1'b0);
        // R8 pulse on the natural wrap
        while (k != 511) step(1'b0);
        step(1'b1);
        check("R8 pulse at wrap address", int'(rd_addr), exp_loc(0));
        for (int i = 0; i < 20; i++) step(1'b0);
        check("R8 sequence continues", int'(rd_addr), exp_loc(20));
        finish_run();
    end

    initial begin
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule